// File: doc/BRIEF.md
# SD Host Register and Interrupt Unit

This block is the register file and interrupt logic of an SD/MMC host controller. A processor reaches it over a plain memory-mapped bus with a word address, write data, combinational read data and one-cycle write and read strobes. A separate command engine reports command completion, timeouts, the card status word of each response and buffer-ready events. The block turns those reports into status bits and drives one level-sensitive interrupt line.

Status produced by events does not appear in the visible status word at once. It first collects in a hidden pending word. Only a read of the status register folds pending into visible status and empties pending, and that read returns the merged word. The interrupt line looks at visible and pending bits together, so an interrupt raised by a fresh event survives a write-one-to-clear that was aimed at older status. Three soft-reset bits in the system-control word each clear a different slice of state. A fourth reset path sits in the system-configuration word. The block also keeps the read and write pointers of the data FIFO, whose storage lives elsewhere.

Top module: `sdh_host_regs`

Register word addresses: 0 revision (read-only, 0x26000000), 1 system config, 2 control, 3 block, 4 argument, 5 command, 6..9 response words 0..3, 10 present state (read-only), 11 host control, 12 system control, 13 status, 14 status enable, 15 signal enable, 16 capabilities, 17 card-status enable.

## Requirements
- R1: A read of status returns (status | pending) in the same cycle. At that clock edge pending is merged into status and emptied. Events arriving in the cycle of the read land in the new pending word and are visible only at the next status read.
- R2: `irq` is high exactly when ((status | pending) & signal-enable & status-enable) is nonzero.
- R3: A status write clears, in visible status only, every bit set in (wdata & 0x317F0237). Pending is untouched by the write, so bit 15 and pending bits survive it.
- R4: On command done, pending bit 16 is set on timeout, otherwise pending bit 0. Bit 28 is set when (card_status & card-status-enable) is nonzero; otherwise bit 28 is cleared in both status and pending. Pending is then ANDed with status-enable. Finally bit 15 is set if any of pending bits 31:16 is set.
- R5: With control bit 1 set, a command write whose index field (bits 29:24) is 0 sets pending bit 0 without the enable mask. It clears present-state bit 0 and emits no `cmd_start`. Any other index issues normally.
- R6: A command write stores wdata & 0x3FFB0037, pulses `cmd_start` one cycle later and sets present-state bit 0. Command done clears present-state bit 0.
- R7: On command done without timeout, the response type in command bits 17:16 selects the capture. Type 01 latches all four response words from `rsp_data`, with word i at bits 32i+31:32i. Types 10 and 11 latch word 0 only. A timeout latches nothing.
- R8: A system-control write with bit 26 set clears present-state bits 0xF06, host-control bits 0x30000, status and pending bits 0x34, and both FIFO pointers.
- R9: System-control bit 25 clears present-state bit 0. Bit 24 resets every register to its reset value except capabilities, which keeps its value.
- R10: A system-control write stores ((wdata with bit 1 replaced by bit 0) & 0x000FFFC7).
- R11: After reset: revision 0x26000000, system config 0x15, control 0x500, present state 0x00040000, capabilities 0x00E10080, everything else 0 and `irq` low.
- R12: A status-enable write stores wdata & 0x317F0337, but bit 9 keeps its old value unless control bit 14 is set. A 0 in the new bit 8 clears bit 8 in status and pending.
- R13: A system-config write with bit 1 set performs a full reset, including capabilities, then stores wdata & 0x31D. A buffer-read-ready event sets pending bit 5 and clears bit 4 in status and pending. A buffer-write-ready event sets pending bit 4 and clears bit 5 in both.
- R14: `fifo_push` and `fifo_pop` each advance their pointer by one, modulo 2^FIFO_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (read side effects at the edge) |
| bus_rdata | output | 32 | Combinational read data |
| evt_cmd_done | input | 1 | Command finished |
| evt_cmd_timeout | input | 1 | Qualifies command done as timed out |
| card_status | input | 32 | Card status word accompanying command done |
| rsp_data | input | 32*RSP_WORDS | Response payload accompanying command done |
| evt_buf_rd | input | 1 | Buffer read-ready event |
| evt_buf_wr | input | 1 | Buffer write-ready event |
| fifo_push | input | 1 | Advance FIFO write pointer |
| fifo_pop | input | 1 | Advance FIFO read pointer |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_word | output | 32 | Stored command word |
| arg_word | output | 32 | Stored argument word |
| irq | output | 1 | Level interrupt |
| fifo_wptr | output | FIFO_AW | FIFO write pointer |
| fifo_rptr | output | FIFO_AW | FIFO read pointer |

## Verification
The bench builds the block with ADDR_W=5 and FIFO_AW=3. A three-bit pointer wraps after eight pushes, so the bench can drive pointer wrap-around before a data-path reset and then see both pointers return to zero. The default address width already covers all eighteen register words, so the whole map stays reachable. The bench also orders events against status reads and writes to show where a bit sits, pending or visible, at each step.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

    localparam int unsigned DW = 32;

    // register word addresses
    localparam int unsigned A_REV    = 0;
    localparam int unsigned A_SYSCFG = 1;
    localparam int unsigned A_CON    = 2;
    localparam int unsigned A_BLK    = 3;
    localparam int unsigned A_ARG    = 4;
    localparam int unsigned A_CMD    = 5;
    localparam int unsigned A_RSP0   = 6;
    localparam int unsigned A_PSTATE = 10;
    localparam int unsigned A_HCTL   = 11;
    localparam int unsigned A_SYSCTL = 12;
    localparam int unsigned A_STAT   = 13;
    localparam int unsigned A_IE     = 14;
    localparam int unsigned A_ISE    = 15;
    localparam int unsigned A_CAPA   = 16;
    localparam int unsigned A_CSEN   = 17;

    // reset values
    localparam logic [DW-1:0] REV_VAL    = 32'h2600_0000;
    localparam logic [DW-1:0] SYSCFG_RST = 32'h0000_0015;
    localparam logic [DW-1:0] CON_RST    = 32'h0000_0500;
    localparam logic [DW-1:0] PSTATE_RST = 32'h0004_0000;
    localparam logic [DW-1:0] CAPA_RST   = 32'h00E1_0080;

    // write masks
    localparam logic [DW-1:0] SYSCFG_MSK = 32'h0000_031D;
    localparam logic [DW-1:0] CON_MSK    = 32'h0001_FFFF;
    localparam logic [DW-1:0] BLK_MSK    = 32'hFFFF_07FF;
    localparam logic [DW-1:0] CMD_MSK    = 32'h3FFB_0037;
    localparam logic [DW-1:0] HCTL_MSK   = 32'h0F0F_0F02;
    localparam logic [DW-1:0] SYSCTL_MSK = 32'h000F_FFC7;
    localparam logic [DW-1:0] STAT_W1C   = 32'h317F_0237;
    localparam logic [DW-1:0] IEN_MSK    = 32'h317F_0337;
    localparam logic [DW-1:0] CAPA_MSK   = 32'h0700_0000;

    // data-path reset clear sets
    localparam logic [DW-1:0] PST_DCLR  = 32'h0000_0F06;
    localparam logic [DW-1:0] HCTL_DCLR = 32'h0003_0000;
    localparam logic [DW-1:0] STAT_DCLR = 32'h0000_0034;

    // status bit positions
    localparam int unsigned B_CC   = 0;
    localparam int unsigned B_BWR  = 4;
    localparam int unsigned B_BRR  = 5;
    localparam int unsigned B_CIRQ = 8;
    localparam int unsigned B_OBI  = 9;
    localparam int unsigned B_ERR  = 15;
    localparam int unsigned B_CTO  = 16;
    localparam int unsigned B_CERR = 28;

    // control / system-control bit positions
    localparam int unsigned C_INIT = 1;
    localparam int unsigned C_OBIE = 14;
    localparam int unsigned S_SRA  = 24;
    localparam int unsigned S_SRC  = 25;
    localparam int unsigned S_SRD  = 26;
    localparam int unsigned G_SRST = 1;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_LONG = 2'b01,
        RSP_SHRT = 2'b10,
        RSP_BUSY = 2'b11
    } rsp_kind_e;

    typedef struct packed {
        logic done;
        logic timeout;
        logic card_err;
        logic buf_rd;
        logic buf_wr;
        logic init_hit;
    } evt_t;

    function automatic logic [DW-1:0] sysctl_fold(input logic [DW-1:0] v);
        logic [DW-1:0] t;
        t = v;
        t[1] = v[0];
        return t & SYSCTL_MSK;
    endfunction

endpackage

// File: rtl/sdh_stat_unit.sv
module sdh_stat_unit
    import sdh_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic [DW-1:0] wdata,
    input  logic          rd_stat,
    input  logic          wr_stat,
    input  logic          wr_ie,
    input  logic          wr_ise,
    input  logic          con_obie,
    input  logic          srd,
    input  evt_t          ev,
    output logic [DW-1:0] stat_o,
    output logic [DW-1:0] pend_o,
    output logic [DW-1:0] view_o,
    output logic [DW-1:0] ie_o,
    output logic [DW-1:0] ise_o,
    output logic          irq
);
    logic [DW-1:0] stat_q, pend_q, ie_q, ise_q;
    logic [DW-1:0] s_n, p_n, ie_n, ise_n;

    always_comb begin
        s_n   = stat_q;
        p_n   = pend_q;
        ie_n  = ie_q;
        ise_n = wr_ise ? (wdata & IEN_MSK) : ise_q;
        if (wr_ie) begin
            ie_n = wdata;
            if (!con_obie) ie_n[B_OBI] = ie_q[B_OBI];
            ie_n = ie_n & IEN_MSK;
        end
        // a read folds pending into visible status first
        if (rd_stat) begin
            s_n = s_n | p_n;
            p_n = '0;
        end
        if (wr_stat) s_n = s_n & ~(wdata & STAT_W1C);
        if (srd) begin
            s_n = s_n & ~STAT_DCLR;
            p_n = p_n & ~STAT_DCLR;
        end
        if (wr_ie && !ie_n[B_CIRQ]) begin
            s_n[B_CIRQ] = 1'b0;
            p_n[B_CIRQ] = 1'b0;
        end
        if (ev.init_hit) p_n[B_CC] = 1'b1;
        if (ev.buf_rd) begin
            p_n[B_BRR] = 1'b1;
            s_n[B_BWR] = 1'b0;
            p_n[B_BWR] = 1'b0;
        end
        if (ev.buf_wr) begin
            p_n[B_BWR] = 1'b1;
            s_n[B_BRR] = 1'b0;
            p_n[B_BRR] = 1'b0;
        end
        if (ev.done) begin
            if (ev.timeout) p_n[B_CTO] = 1'b1;
            else            p_n[B_CC]  = 1'b1;
            if (ev.card_err) p_n[B_CERR] = 1'b1;
            else begin
                s_n[B_CERR] = 1'b0;
                p_n[B_CERR] = 1'b0;
            end
            p_n = p_n & ie_n;
            if (|p_n[31:16]) p_n[B_ERR] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            stat_q <= '0;
            pend_q <= '0;
            ie_q   <= '0;
            ise_q  <= '0;
        end else begin
            stat_q <= s_n;
            pend_q <= p_n;
            ie_q   <= ie_n;
            ise_q  <= ise_n;
        end
    end

    assign stat_o = stat_q;
    assign pend_o = pend_q;
    assign view_o = stat_q | pend_q;
    assign ie_o   = ie_q;
    assign ise_o  = ise_q;
    assign irq    = |((stat_q | pend_q) & ie_q & ise_q);
endmodule

// File: rtl/sdh_resp_regs.sv
module sdh_resp_regs
    import sdh_pkg::*;
#(
    parameter int unsigned NW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap_long,
    input  logic             cap_short,
    input  logic [NW*DW-1:0] rsp_in,
    output logic [NW*DW-1:0] words
);
    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam bit LOW = (i == 0);
        logic [DW-1:0] w_q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                w_q <= '0;
            else if (cap_long || (LOW && cap_short))
                w_q <= rsp_in[i*DW +: DW];
        end
        assign words[i*DW +: DW] = w_q;
    end
endmodule

// File: rtl/sdh_fifo_ptrs.sv
module sdh_fifo_ptrs #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/sdh_host_regs.sv
module sdh_host_regs
    import sdh_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned FIFO_AW   = 8,
    parameter int unsigned RSP_WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    input  logic                    bus_we,
    input  logic                    bus_re,
    output logic [31:0]             bus_rdata,
    input  logic                    evt_cmd_done,
    input  logic                    evt_cmd_timeout,
    input  logic [31:0]             card_status,
    input  logic [32*RSP_WORDS-1:0] rsp_data,
    input  logic                    evt_buf_rd,
    input  logic                    evt_buf_wr,
    input  logic                    fifo_push,
    input  logic                    fifo_pop,
    output logic                    cmd_start,
    output logic [31:0]             cmd_word,
    output logic [31:0]             arg_word,
    output logic                    irq,
    output logic [FIFO_AW-1:0]      fifo_wptr,
    output logic [FIFO_AW-1:0]      fifo_rptr
);
    localparam int unsigned RSP_LAST = A_RSP0 + RSP_WORDS - 1;

    logic [DW-1:0] syscfg_q, con_q, blk_q, arg_q, cmd_q, pstate_q;
    logic [DW-1:0] hctl_q, sysctl_q, capa_q, csen_q;
    logic [DW-1:0] stat_w, pend_w, view_w, ie_w, ise_w;
    logic [RSP_WORDS*DW-1:0] rsp_w;

    logic wr_syscfg, wr_con, wr_blk, wr_arg, wr_cmd, wr_hctl, wr_sysctl;
    logic wr_stat, wr_ie, wr_ise, wr_capa, wr_csen, rd_stat;
    logic soft_full, keep_capa, srd, init_hit, rsp_ok;
    evt_t ev;

    assign wr_syscfg = bus_we && bus_addr == ADDR_W'(A_SYSCFG);
    assign wr_con    = bus_we && bus_addr == ADDR_W'(A_CON);
    assign wr_blk    = bus_we && bus_addr == ADDR_W'(A_BLK);
    assign wr_arg    = bus_we && bus_addr == ADDR_W'(A_ARG);
    assign wr_cmd    = bus_we && bus_addr == ADDR_W'(A_CMD);
    assign wr_hctl   = bus_we && bus_addr == ADDR_W'(A_HCTL);
    assign wr_sysctl = bus_we && bus_addr == ADDR_W'(A_SYSCTL);
    assign wr_stat   = bus_we && bus_addr == ADDR_W'(A_STAT);
    assign wr_ie     = bus_we && bus_addr == ADDR_W'(A_IE);
    assign wr_ise    = bus_we && bus_addr == ADDR_W'(A_ISE);
    assign wr_capa   = bus_we && bus_addr == ADDR_W'(A_CAPA);
    assign wr_csen   = bus_we && bus_addr == ADDR_W'(A_CSEN);
    assign rd_stat   = bus_re && bus_addr == ADDR_W'(A_STAT);

    assign keep_capa = wr_sysctl && bus_wdata[S_SRA];
    assign soft_full = keep_capa || (wr_syscfg && bus_wdata[G_SRST]);
    assign srd       = wr_sysctl && bus_wdata[S_SRD];
    assign init_hit  = wr_cmd && con_q[C_INIT] && bus_wdata[29:24] == 6'd0;
    assign rsp_ok    = evt_cmd_done && !evt_cmd_timeout;

    always_comb begin
        ev          = '0;
        ev.done     = evt_cmd_done;
        ev.timeout  = evt_cmd_timeout;
        ev.card_err = |(card_status & csen_q);
        ev.buf_rd   = evt_buf_rd;
        ev.buf_wr   = evt_buf_wr;
        ev.init_hit = init_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syscfg_q <= SYSCFG_RST;  con_q    <= CON_RST;
            blk_q    <= '0;          arg_q    <= '0;
            cmd_q    <= '0;          pstate_q <= PSTATE_RST;
            hctl_q   <= '0;          sysctl_q <= '0;
            capa_q   <= CAPA_RST;    csen_q   <= '0;
            cmd_start <= 1'b0;
        end else begin
            cmd_start <= 1'b0;
            if (soft_full) begin
                syscfg_q <= SYSCFG_RST;  con_q    <= CON_RST;
                blk_q    <= '0;          arg_q    <= '0;
                cmd_q    <= '0;          pstate_q <= PSTATE_RST;
                hctl_q   <= '0;          sysctl_q <= '0;
                csen_q   <= '0;
                if (!keep_capa) capa_q <= CAPA_RST;
            end else begin
                if (wr_con)  con_q  <= bus_wdata & CON_MSK;
                if (wr_blk)  blk_q  <= bus_wdata & BLK_MSK;
                if (wr_arg)  arg_q  <= bus_wdata;
                if (wr_hctl) hctl_q <= bus_wdata & HCTL_MSK;
                if (wr_capa) capa_q <= bus_wdata & CAPA_MSK;
                if (wr_csen) csen_q <= bus_wdata;
                if (evt_cmd_done) pstate_q[0] <= 1'b0;
                if (wr_cmd) begin
                    cmd_q <= bus_wdata & CMD_MSK;
                    if (init_hit) pstate_q[0] <= 1'b0;
                    else begin
                        pstate_q[0] <= 1'b1;
                        cmd_start   <= 1'b1;
                    end
                end
                if (wr_sysctl) begin
                    if (bus_wdata[S_SRD]) begin
                        pstate_q <= pstate_q & ~PST_DCLR;
                        hctl_q   <= hctl_q & ~HCTL_DCLR;
                    end
                    if (bus_wdata[S_SRC]) pstate_q[0] <= 1'b0;
                end
            end
            if (wr_syscfg) syscfg_q <= bus_wdata & SYSCFG_MSK;
            if (wr_sysctl) sysctl_q <= sysctl_fold(bus_wdata);
        end
    end

    sdh_stat_unit u_stat (
        .clk(clk), .rst(rst), .soft_rst(soft_full), .wdata(bus_wdata),
        .rd_stat(rd_stat), .wr_stat(wr_stat), .wr_ie(wr_ie), .wr_ise(wr_ise),
        .con_obie(con_q[C_OBIE]), .srd(srd), .ev(ev),
        .stat_o(stat_w), .pend_o(pend_w), .view_o(view_w),
        .ie_o(ie_w), .ise_o(ise_w), .irq(irq)
    );

    sdh_resp_regs #(.NW(RSP_WORDS)) u_rsp (
        .clk(clk), .rst(rst), .clr(soft_full),
        .cap_long(rsp_ok && cmd_q[17:16] == RSP_LONG),
        .cap_short(rsp_ok && (cmd_q[17:16] == RSP_SHRT || cmd_q[17:16] == RSP_BUSY)),
        .rsp_in(rsp_data), .words(rsp_w)
    );

    sdh_fifo_ptrs #(.AW(FIFO_AW)) u_fifo (
        .clk(clk), .rst(rst), .clr(soft_full || srd),
        .push(fifo_push), .pop(fifo_pop), .wptr(fifo_wptr), .rptr(fifo_rptr)
    );

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) >= A_RSP0 && int'(bus_addr) <= RSP_LAST)
            bus_rdata = rsp_w[(int'(bus_addr) - A_RSP0)*DW +: DW];
        else begin
            case (int'(bus_addr))
                A_REV:    bus_rdata = REV_VAL;
                A_SYSCFG: bus_rdata = syscfg_q;
                A_CON:    bus_rdata = con_q;
                A_BLK:    bus_rdata = blk_q;
                A_ARG:    bus_rdata = arg_q;
                A_CMD:    bus_rdata = cmd_q;
                A_PSTATE: bus_rdata = pstate_q;
                A_HCTL:   bus_rdata = hctl_q;
                A_SYSCTL: bus_rdata = sysctl_q;
                A_STAT:   bus_rdata = view_w;
                A_IE:     bus_rdata = ie_w;
                A_ISE:    bus_rdata = ise_w;
                A_CAPA:   bus_rdata = capa_q;
                A_CSEN:   bus_rdata = csen_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign cmd_word = cmd_q;
    assign arg_word = arg_q;
endmodule

// File: rtl/sdh_host_regs_chk.sv
module sdh_host_regs_chk
    import sdh_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned FIFO_AW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               bus_we,
    input logic               bus_re,
    input logic               evt_cmd_done,
    input logic               evt_buf_rd,
    input logic               evt_buf_wr,
    input logic [31:0]        con_q,
    input logic [31:0]        pstate_q,
    input logic [31:0]        sysctl_q,
    input logic [31:0]        stat_w,
    input logic [31:0]        pend_w,
    input logic               cmd_start,
    input logic [FIFO_AW-1:0] fifo_wptr,
    input logic [FIFO_AW-1:0] fifo_rptr
);
    logic quiet, at_stat;
    assign quiet   = !evt_cmd_done && !evt_buf_rd && !evt_buf_wr;
    assign at_stat = bus_addr == ADDR_W'(A_STAT);

    AST_READ_EMPTIES_PEND: assert property (@(posedge clk) disable iff (rst)
        bus_re && !bus_we && at_stat && quiet |=> pend_w == '0); // R1

    AST_WRITE_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
        bus_we && !bus_re && at_stat && quiet |=> pend_w == $past(pend_w)); // R3

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        evt_cmd_done && !(bus_re && at_stat) |=> (pend_w[31:16] == '0) || pend_w[B_ERR]); // R4

    AST_INIT_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr == ADDR_W'(A_CMD) && con_q[C_INIT] && bus_wdata[29:24] == 6'd0
        |=> !cmd_start && !pstate_q[0]); // R5

    AST_DATA_RESET: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr == ADDR_W'(A_SYSCTL) && bus_wdata[S_SRD]
        |=> fifo_wptr == '0 && fifo_rptr == '0 && (stat_w & STAT_DCLR) == '0); // R8

    AST_CLOCK_STABLE_COPY: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr == ADDR_W'(A_SYSCTL) |=> sysctl_q[1] == $past(bus_wdata[0])); // R10
endmodule

bind sdh_host_regs sdh_host_regs_chk #(.ADDR_W(ADDR_W), .FIFO_AW(FIFO_AW)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .evt_cmd_done(evt_cmd_done),
    .evt_buf_rd(evt_buf_rd), .evt_buf_wr(evt_buf_wr), .con_q(con_q),
    .pstate_q(pstate_q), .sysctl_q(sysctl_q), .stat_w(stat_w), .pend_w(pend_w),
    .cmd_start(cmd_start), .fifo_wptr(fifo_wptr), .fifo_rptr(fifo_rptr)
);

// File: tb/sdh_host_regs_tb.sv
module sdh_host_regs_tb;
    localparam int AW = 5;
    localparam int FAW = 3;

    localparam int R_REV = 0, R_SCFG = 1, R_CON = 2, R_CMD = 5, R_RSP0 = 6;
    localparam int R_PST = 10, R_HCTL = 11, R_SCTL = 12, R_STAT = 13;
    localparam int R_IE = 14, R_ISE = 15, R_CAPA = 16, R_CSEN = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic evt_cmd_done = 1'b0, evt_cmd_timeout = 1'b0;
    logic [31:0] card_status = '0;
    logic [127:0] rsp_data = '0;
    logic evt_buf_rd = 1'b0, evt_buf_wr = 1'b0;
    logic fifo_push = 1'b0, fifo_pop = 1'b0;
    logic cmd_start, irq;
    logic [31:0] cmd_word, arg_word;
    logic [FAW-1:0] fifo_wptr, fifo_rptr;

    int total = 0;
    int bad = 0;
    logic last_start;
    logic [31:0] rv;

    always #4 clk = ~clk;

    sdh_host_regs #(.ADDR_W(AW), .FIFO_AW(FAW), .RSP_WORDS(4)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .evt_cmd_done(evt_cmd_done), .evt_cmd_timeout(evt_cmd_timeout),
        .card_status(card_status), .rsp_data(rsp_data),
        .evt_buf_rd(evt_buf_rd), .evt_buf_wr(evt_buf_wr),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .cmd_start(cmd_start), .cmd_word(cmd_word), .arg_word(arg_word),
        .irq(irq), .fifo_wptr(fifo_wptr), .fifo_rptr(fifo_rptr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        last_start = cmd_start;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic done(input logic to, input logic [31:0] cs, input logic [127:0] rsp);
        @(negedge clk);
        evt_cmd_done = 1'b1; evt_cmd_timeout = to; card_status = cs; rsp_data = rsp;
        @(negedge clk);
        evt_cmd_done = 1'b0; evt_cmd_timeout = 1'b0;
    endtask

    task automatic buf_ev(input logic rdy_rd);
        @(negedge clk);
        evt_buf_rd = rdy_rd; evt_buf_wr = !rdy_rd;
        @(negedge clk);
        evt_buf_rd = 1'b0; evt_buf_wr = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R11 rev", R_REV, 32'h2600_0000);
        rd_chk("R11 syscfg", R_SCFG, 32'h0000_0015);
        rd_chk("R11 con", R_CON, 32'h0000_0500);
        rd_chk("R11 pstate", R_PST, 32'h0004_0000);
        rd_chk("R11 capa", R_CAPA, 32'h00E1_0080);
        rd_chk("R11 stat", R_STAT, 32'h0);
        chk("R11 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_issue_basic;
        wr(R_IE, 32'hFFFF_FFFF);
        rd_chk("R12 ie obi held", R_IE, 32'h317F_0137);
        wr(R_ISE, 32'hFFFF_FFFF);
        wr(R_CMD, 32'hFFFF_FFFF);
        chk("R6 start pulse", {31'd0, last_start}, 32'h1);
        rd_chk("R6 cmd mask", R_CMD, 32'h3FFB_0037);
        rd_chk("R6 inhibit set", R_PST, 32'h0004_0001);
        done(1'b0, 32'h0, {96'd0, 32'hCAFE_F00D});
        chk("R2 irq from pending", {31'd0, irq}, 32'h1);
        rd_chk("R6 inhibit clr", R_PST, 32'h0004_0000);
        rd_chk("R1 merge", R_STAT, 32'h0000_0001);
        rd_chk("R7 short rsp", R_RSP0, 32'hCAFE_F00D);
        wr(R_STAT, 32'hFFFF_FFFF);
        rd_chk("R3 cleared", R_STAT, 32'h0);
        chk("R2 irq low", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_timeout_cerr;
        done(1'b1, 32'h0, {4{32'h1234_5678}});
        chk("R2 irq timeout", {31'd0, irq}, 32'h1);
        rd_chk("R4 timeout+summary", R_STAT, 32'h0001_8000);
        rd_chk("R7 no capture on timeout", R_RSP0, 32'hCAFE_F00D);
        wr(R_STAT, 32'hFFFF_FFFF);
        rd_chk("R3 bit15 not clearable", R_STAT, 32'h0000_8000);
        wr(R_CSEN, 32'h0000_0080);
        done(1'b0, 32'h0000_0080, '0);
        rd_chk("R4 card err", R_STAT, 32'h1000_8001);
        done(1'b0, 32'h0, '0);
        rd_chk("R4 card err cleared", R_STAT, 32'h0000_8001);
        wr(R_IE, 32'h0);
        done(1'b0, 32'h0, '0);
        rd_chk("R4 masked by enable", R_STAT, 32'h0000_8001);
        chk("R2 irq masked", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_soft_all;
        wr(R_CAPA, 32'hFFFF_FFFF);
        wr(R_CON, 32'h0000_0003);
        wr(R_SCTL, 32'h0100_0000);
        rd_chk("R9 con reset", R_CON, 32'h0000_0500);
        rd_chk("R9 capa kept", R_CAPA, 32'h0700_0000);
        rd_chk("R9 stat reset", R_STAT, 32'h0);
        rd_chk("R9 ie reset", R_IE, 32'h0);
    endtask

    task automatic t_pending_survives;
        wr(R_IE, 32'hFFFF_FFFF);
        wr(R_ISE, 32'h0000_0001);
        done(1'b0, 32'h0, '0);
        wr(R_STAT, 32'h0000_0001);
        chk("R3 pending holds irq", {31'd0, irq}, 32'h1);
        rd_chk("R3 pending kept", R_STAT, 32'h0000_0001);
        wr(R_STAT, 32'h0000_0001);
        chk("R3 irq cleared", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_back_to_back;
        logic [31:0] d;
        done(1'b0, 32'h0, '0);
        @(negedge clk);
        bus_addr = AW'(R_STAT); bus_re = 1'b1; evt_buf_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; evt_buf_rd = 1'b0;
        chk("R1 read ignores same-cycle event", d, 32'h0000_0001);
        rd_chk("R1 event lands next read", R_STAT, 32'h0000_0021);
        buf_ev(1'b0);
        rd_chk("R13 write-ready swaps", R_STAT, 32'h0000_0011);
    endtask

    task automatic t_ie_rules;
        wr(R_CON, 32'h0000_4000);
        wr(R_IE, 32'hFFFF_FFFF);
        rd_chk("R12 obi allowed", R_IE, 32'h317F_0337);
        wr(R_CON, 32'h0);
        wr(R_IE, 32'h0);
        rd_chk("R12 obi sticky", R_IE, 32'h0000_0200);
    endtask

    task automatic t_init;
        wr(R_STAT, 32'hFFFF_FFFF);
        wr(R_CON, 32'h0000_0002);
        wr(R_CMD, 32'h0000_0000);
        chk("R5 no start", {31'd0, last_start}, 32'h0);
        rd_chk("R5 inhibit clear", R_PST, 32'h0004_0000);
        rd_chk("R5 complete unmasked", R_STAT, 32'h0000_0001);
        wr(R_CMD, 32'h0500_0000);
        chk("R5 other index issues", {31'd0, last_start}, 32'h1);
        rd_chk("R5 inhibit set", R_PST, 32'h0004_0001);
        wr(R_CON, 32'h0);
        done(1'b0, 32'h0, '0);
    endtask

    task automatic t_long_rsp;
        wr(R_CMD, 32'h0201_0000);
        done(1'b0, 32'h0, {32'hD3D3_0003, 32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000});
        for (int i = 0; i < 4; i++) begin
            logic [31:0] e;
            e = {8'hA0 + 8'(i * 8'h11), 8'hA0 + 8'(i * 8'h11), 16'(i)};
            rd_chk("R7 long word", R_RSP0 + i, e);
        end
    endtask

    task automatic t_data_reset;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); fifo_push = 1'b1; fifo_pop = (i < 3);
        end
        @(negedge clk); fifo_push = 1'b0; fifo_pop = 1'b0;
        chk("R14 wptr wrap", 32'(fifo_wptr), 32'h2);
        chk("R14 rptr", 32'(fifo_rptr), 32'h3);
        wr(R_HCTL, 32'hFFFF_FFFF);
        rd_chk("R8 hctl mask", R_HCTL, 32'h0F0F_0F02);
        buf_ev(1'b1);
        rd_chk("R13 read-ready", R_STAT, 32'h0000_0021);
        wr(R_SCTL, 32'h0400_0000);
        chk("R8 ptrs zero", {16'(fifo_wptr), 16'(fifo_rptr)}, 32'h0);
        rd_chk("R8 hctl cleared", R_HCTL, 32'h0F0C_0F02);
        rd_chk("R8 stat cleared", R_STAT, 32'h0000_0001);
        rd_chk("R10 sysctl after srd", R_SCTL, 32'h0);
    endtask

    task automatic t_sysctl_misc;
        wr(R_CMD, 32'h0500_0000);
        wr(R_SCTL, 32'h0200_0000);
        rd_chk("R9 cmd line reset", R_PST, 32'h0004_0000);
        wr(R_SCTL, 32'h0000_0005);
        rd_chk("R10 ics copy set", R_SCTL, 32'h0000_0007);
        wr(R_SCTL, 32'h0000_0002);
        rd_chk("R10 ics copy clr", R_SCTL, 32'h0);
        wr(R_SCTL, 32'hFFFF_FFFE);
        rd_chk("R10 mask", R_SCTL, 32'h000F_FFC4);
    endtask

    task automatic t_syscfg;
        wr(R_CON, 32'h0000_0123);
        wr(R_CAPA, 32'h0);
        wr(R_SCFG, 32'h0000_0FFF);
        rd_chk("R13 syscfg mask", R_SCFG, 32'h0000_031D);
        rd_chk("R13 con reset", R_CON, 32'h0000_0500);
        rd_chk("R13 capa reset", R_CAPA, 32'h00E1_0080);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_issue_basic();
        t_timeout_cerr();
        t_soft_all();
        t_pending_survives();
        t_back_to_back();
        t_ie_rules();
        t_init();
        t_long_rsp();
        t_data_reset();
        t_sysctl_misc();
        t_syscfg();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule